// File: doc/BRIEF.md
# Super I/O Index/Data Configuration Port

This block sits behind a byte-wide I/O bus and exposes a 256-entry configuration byte space through two ports. Software first writes an entry number to the index port. Reads and writes on the data port then reach that entry. A bridge-side configuration bit drives the enable input. While that input is low, the block decodes neither port: it ignores every access and returns nothing.

Only a small window at the top of the index space holds storage. Inside that window, a protection mask makes some entries read-only. Every entry below the window is read-only and reads as zero. Six writable entries come out of reset with fixed contents. Two of those entries hold the base addresses of two serial ports. When software writes either of them with a value other than its supported one, a sticky flag for that port goes high. The written value is still stored.

Top module: `sio_cfg_port`

## Requirements
- R1: Reset clears the index register to 0x00 and clears both flags, `io_rvalid` and `io_rdata`. After reset, entry 0xE0 holds 0x3C, 0xE2 holds 0x03, 0xE3 holds 0xFC, 0xE6 holds 0xDE, 0xE7 holds 0xFE and 0xE8 holds 0xBE. Every other entry holds 0x00.
- R2: While `decode_en` is high, a write strobe at offset 0xF0 loads `io_wdata` into the index register. A read strobe at offset 0xF0 returns the current index in the cycle after the strobe.
- R3: While `decode_en` is high, a read strobe at offset 0xF1 returns the entry selected by the index. The result appears in the cycle after the strobe, and `io_rvalid` is high for that one cycle. Whenever `io_rvalid` is low, `io_rdata` is 0x00.
- R4: A write strobe at offset 0xF1 stores `io_wdata` in the selected entry when that entry is writable. The writable entries are 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R5: Every other entry is read-only: 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF. A data write to a read-only entry leaves its contents unchanged.
- R6: While `decode_en` is low, every strobe is ignored. No state changes, and `io_rvalid` stays low.
- R7: A data write to entry 0xE7 with any value other than 0xFE sets `ser1_base_bad`. The flag stays set until reset. Writing 0xFE does not set it.
- R8: A data write to entry 0xE8 with any value other than 0xBE sets `ser2_base_bad`. The flag stays set until reset. Writing 0xBE does not set it.
- R9: If a read strobe and a write strobe hit the data port in the same cycle, the read returns the entry's contents from before the write.
- R10: Strobes at any offset other than 0xF0 and 0xF1 change no state and produce no `io_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decode_en | input | 1 | Port pair decoded while high (bridge configuration bit) |
| io_addr | input | 8 | I/O address offset of the access |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, 0x00 when not valid |
| io_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| ser1_base_bad | output | 1 | Sticky flag: unsupported value written to entry 0xE7 |
| ser2_base_bad | output | 1 | Sticky flag: unsupported value written to entry 0xE8 |

## Verification
A wrong index register corrupts the next data read, one cycle after the strobe. An index read on the port exposes it directly. A flaw in the protection map or in a reset constant only shows when the affected entry is read back. For that reason the bench sweeps every one of the 256 entries: once after reset, and again after writing each entry with a value derived from its number. A flag that fails to set, or that clears by itself, shows on its output pin at the first clock edge after the offending write.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

   localparam int unsigned ENTRY_W = 8;

   // Contents an entry takes on reset; unlisted entries clear to zero
   function automatic logic [ENTRY_W-1:0] entry_reset(input logic [ENTRY_W-1:0] idx);
      case (idx)
         8'hE0:   return 8'h3C;
         8'hE2:   return 8'h03;
         8'hE3:   return 8'hFC;
         8'hE6:   return 8'hDE;
         8'hE7:   return 8'hFE;
         8'hE8:   return 8'hBE;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned IDX_OFS = 'hF0,
   parameter int unsigned DAT_OFS = 'hF1
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output logic              idx_wr,
   output logic              dat_wr,
   output logic              idx_rd,
   output logic              dat_rd
);
   localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(IDX_OFS);
   localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(DAT_OFS);

   logic hit_idx, hit_dat;

   always_comb begin
      hit_idx = en && (addr == A_IDX);
      hit_dat = en && (addr == A_DAT);
      idx_wr  = hit_idx && wr;
      dat_wr  = hit_dat && wr;
      idx_rd  = hit_idx && rd;
      dat_rd  = hit_dat && rd;
   end
endmodule

// File: rtl/sio_cfg_array.sv
module sio_cfg_array #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned WIN_BASE  = 'hE0,
   parameter int unsigned WIN_DEPTH = 32,
   parameter logic [WIN_DEPTH-1:0] RO_MASK = 32'hEEA8_3E30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned OFS_W = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;
   localparam logic [DATA_W:0] WIN_LO = (DATA_W+1)'(WIN_BASE);
   localparam logic [DATA_W:0] WIN_HI = (DATA_W+1)'(WIN_BASE + WIN_DEPTH);

   logic [DATA_W-1:0] ent [WIN_DEPTH];
   logic              wr_hit, rd_hit;
   logic [OFS_W-1:0]  wr_ofs, rd_ofs;
   logic [DATA_W-1:0] wr_rel, rd_rel;

   always_comb begin
      wr_hit = ({1'b0, wr_idx} >= WIN_LO) && ({1'b0, wr_idx} < WIN_HI);
      rd_hit = ({1'b0, rd_idx} >= WIN_LO) && ({1'b0, rd_idx} < WIN_HI);
      wr_rel = wr_idx - DATA_W'(WIN_BASE);
      rd_rel = rd_idx - DATA_W'(WIN_BASE);
      wr_ofs = wr_rel[OFS_W-1:0];
      rd_ofs = rd_rel[OFS_W-1:0];
   end

   for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_ent
      localparam logic [7:0] MY_IDX = 8'(WIN_BASE + g);
      localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(sio_cfg_pkg::entry_reset(MY_IDX));
      if (RO_MASK[g]) begin : g_fixed
         assign ent[g] = RST_VAL;
      end else begin : g_store
         logic [DATA_W-1:0] val;
         always_ff @(posedge clk) begin
            if (!rst_n)
               val <= RST_VAL;
            else if (wr_en && wr_hit && (wr_ofs == OFS_W'(g)))
               val <= wr_data;
         end
         assign ent[g] = val;
      end
   end

   always_comb rd_data = rd_hit ? ent[rd_ofs] : '0;
endmodule

// File: rtl/sio_cfg_watch.sv
module sio_cfg_watch #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned WATCH_IDX = 'hE7,
   parameter int unsigned GOOD_VAL  = 'hFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] idx,
   input  logic [DATA_W-1:0] data,
   output logic              bad
);
   localparam logic [DATA_W-1:0] W_IDX = DATA_W'(WATCH_IDX);
   localparam logic [DATA_W-1:0] W_OK  = DATA_W'(GOOD_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n)
         bad <= 1'b0;
      else if (wr_en && (idx == W_IDX) && (data != W_OK))
         bad <= 1'b1;
   end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned IDX_OFS   = 'hF0,
   parameter int unsigned DAT_OFS   = 'hF1,
   parameter int unsigned WIN_BASE  = 'hE0,
   parameter int unsigned WIN_DEPTH = 32,
   parameter logic [WIN_DEPTH-1:0] RO_MASK = 32'hEEA8_3E30,
   parameter int unsigned SER1_IDX  = 'hE7,
   parameter int unsigned SER1_OK   = 'hFE,
   parameter int unsigned SER2_IDX  = 'hE8,
   parameter int unsigned SER2_OK   = 'hBE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              decode_en,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_rvalid,
   output logic              ser1_base_bad,
   output logic              ser2_base_bad
);
   initial begin
      assert (DATA_W == sio_cfg_pkg::ENTRY_W) else $error("DATA_W must match entry width");
      assert (IDX_OFS != DAT_OFS) else $error("index and data offsets collide");
      assert ((WIN_DEPTH & (WIN_DEPTH - 1)) == 0) else $error("WIN_DEPTH not a power of two");
      assert (WIN_BASE + WIN_DEPTH <= (1 << DATA_W)) else $error("window exceeds index space");
      assert (IDX_OFS < (1 << ADDR_W) && DAT_OFS < (1 << ADDR_W)) else $error("offset too wide");
   end

   logic              idx_wr, dat_wr, idx_rd, dat_rd;
   logic [DATA_W-1:0] idx_q;
   logic [DATA_W-1:0] arr_rd;
   logic [DATA_W-1:0] rd_mux;

   sio_cfg_decode #(
      .ADDR_W(ADDR_W), .IDX_OFS(IDX_OFS), .DAT_OFS(DAT_OFS)
   ) u_dec (
      .en(decode_en), .addr(io_addr), .wr(io_wr), .rd(io_rd),
      .idx_wr(idx_wr), .dat_wr(dat_wr), .idx_rd(idx_rd), .dat_rd(dat_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (idx_wr)
         idx_q <= io_wdata;
   end

   sio_cfg_array #(
      .DATA_W(DATA_W), .WIN_BASE(WIN_BASE), .WIN_DEPTH(WIN_DEPTH), .RO_MASK(RO_MASK)
   ) u_arr (
      .clk(clk), .rst_n(rst_n), .wr_en(dat_wr), .wr_idx(idx_q),
      .wr_data(io_wdata), .rd_idx(idx_q), .rd_data(arr_rd)
   );

   sio_cfg_watch #(
      .DATA_W(DATA_W), .WATCH_IDX(SER1_IDX), .GOOD_VAL(SER1_OK)
   ) u_watch1 (
      .clk(clk), .rst_n(rst_n), .wr_en(dat_wr), .idx(idx_q),
      .data(io_wdata), .bad(ser1_base_bad)
   );

   sio_cfg_watch #(
      .DATA_W(DATA_W), .WATCH_IDX(SER2_IDX), .GOOD_VAL(SER2_OK)
   ) u_watch2 (
      .clk(clk), .rst_n(rst_n), .wr_en(dat_wr), .idx(idx_q),
      .data(io_wdata), .bad(ser2_base_bad)
   );

   always_comb rd_mux = idx_rd ? idx_q : arr_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_rvalid <= 1'b0;
         io_rdata  <= '0;
      end else begin
         io_rvalid <= idx_rd || dat_rd;
         io_rdata  <= (idx_rd || dat_rd) ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned IDX_OFS  = 'hF0,
   parameter int unsigned DAT_OFS  = 'hF1,
   parameter int unsigned SER1_IDX = 'hE7,
   parameter int unsigned SER1_OK  = 'hFE,
   parameter int unsigned SER2_IDX = 'hE8,
   parameter int unsigned SER2_OK  = 'hBE
) (
   input logic              clk,
   input logic              rst_n,
   input logic              decode_en,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic              io_rvalid,
   input logic              ser1_base_bad,
   input logic              ser2_base_bad,
   input logic [DATA_W-1:0] cur_idx
);
   logic at_idx, at_dat;
   always_comb begin
      at_idx = decode_en && (io_addr == ADDR_W'(IDX_OFS));
      at_dat = decode_en && (io_addr == ADDR_W'(DAT_OFS));
   end

   // R2: index write loads the bus byte
   a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
      (at_idx && io_wr) |=> (cur_idx == $past(io_wdata)));

   // R2: index read returns the index seen at the strobe
   a_r2_index_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (at_idx && io_rd) |=> (io_rvalid && io_rdata == $past(cur_idx)));

   // R3: accepted data read yields valid next cycle
   a_r3_data_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (at_dat && io_rd) |=> io_rvalid);

   // R3: quiet read bus
   a_r3_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rvalid |-> (io_rdata == '0));

   // R6 / R10: no valid without an accepted read
   a_r6_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !((at_idx || at_dat) && io_rd) |=> !io_rvalid);

   // R6 / R10: index holds without an accepted index write
   a_r6_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(at_idx && io_wr) |=> $stable(cur_idx));

   // R7: flag is sticky and only rises on a bad write
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ser1_base_bad |=> ser1_base_bad);
   a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser1_base_bad) |-> $past(at_dat && io_wr && cur_idx == DATA_W'(SER1_IDX)
                                     && io_wdata != DATA_W'(SER1_OK)));

   // R8: same for the second serial base
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ser2_base_bad |=> ser2_base_bad);
   a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser2_base_bad) |-> $past(at_dat && io_wr && cur_idx == DATA_W'(SER2_IDX)
                                     && io_wdata != DATA_W'(SER2_OK)));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_OFS(IDX_OFS), .DAT_OFS(DAT_OFS),
   .SER1_IDX(SER1_IDX), .SER1_OK(SER1_OK), .SER2_IDX(SER2_IDX), .SER2_OK(SER2_OK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .decode_en(decode_en), .io_addr(io_addr),
   .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
   .io_rvalid(io_rvalid), .ser1_base_bad(ser1_base_bad),
   .ser2_base_bad(ser2_base_bad), .cur_idx(idx_q)
);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
   logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [7:0] addr = 8'h00, wdata = 8'h00;
   logic [7:0] rdata;
   logic       rvalid, bad1, bad2;
   int         checks = 0, errors = 0;
   bit         done = 0;
   logic [7:0] model [256];

   always #10 clk = ~clk;

   sio_cfg_port u0 (
      .clk(clk), .rst_n(rst_n), .decode_en(en), .io_addr(addr), .io_wr(wr),
      .io_rd(rd), .io_wdata(wdata), .io_rdata(rdata), .io_rvalid(rvalid),
      .ser1_base_bad(bad1), .ser2_base_bad(bad2)
   );

   function automatic bit is_ro(int i);
      return (i < 'hE0) || i == 'hE4 || i == 'hE5 || (i >= 'hE9 && i <= 'hED) ||
             i == 'hF3 || i == 'hF5 || i == 'hF7 || (i >= 'hF9 && i <= 'hFB) || i >= 'hFD;
   endfunction

   function automatic logic [7:0] rst_val(int i);
      case (i)
         'hE0: return 8'h3C;  'hE2: return 8'h03;  'hE3: return 8'hFC;
         'hE6: return 8'hDE;  'hE7: return 8'hFE;  'hE8: return 8'hBE;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic do_rd(input logic [7:0] a, output logic v, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0; v = rvalid; d = rdata;
   endtask

   task automatic rd_entry(input int i, input logic [7:0] exp, input string req);
      logic v; logic [7:0] d;
      do_wr(8'hF0, 8'(i));
      do_rd(8'hF1, v, d);
      check(req, v, 1);
      check(req, d, exp);
   endtask

   task automatic apply_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 256; i++) model[i] = rst_val(i);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic v; logic [7:0] d;
      en = 1'b1;
      repeat (3) @(negedge clk);
      // R1: outputs in reset
      check("R1 rvalid", rvalid, 0);
      check("R1 rdata", rdata, 0);
      check("R1 flag1", bad1, 0);
      check("R1 flag2", bad2, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 256; i++) model[i] = rst_val(i);
      // R1/R2: index reset value read through the index port
      do_rd(8'hF0, v, d);
      check("R1 R2 index", {v, d}, {1'b1, 8'h00});
      // R1: every entry reset value (R5 for read-only entries)
      for (int i = 0; i < 256; i++) rd_entry(i, model[i], "R1");
      // R7/R8: supported values leave flags clear
      do_wr(8'hF0, 8'hE7); do_wr(8'hF1, 8'hFE);
      do_wr(8'hF0, 8'hE8); do_wr(8'hF1, 8'hBE);
      check("R7 good value", bad1, 0);
      check("R8 good value", bad2, 0);
      // R7: bad value sets only flag 1, value stored
      do_wr(8'hF0, 8'hE7); do_wr(8'hF1, 8'h12);
      check("R7 set", bad1, 1);
      check("R8 untouched", bad2, 0);
      model['hE7] = 8'h12;
      rd_entry('hE7, 8'h12, "R7 stored");
      // R8: bad value sets flag 2
      do_wr(8'hF0, 8'hE8); do_wr(8'hF1, 8'h34);
      check("R8 set", bad2, 1);
      model['hE8] = 8'h34;
      // R7: sticky after a good value
      do_wr(8'hF0, 8'hE7); do_wr(8'hF1, 8'hFE);
      model['hE7] = 8'hFE;
      check("R7 sticky", bad1, 1);
      check("R8 sticky", bad2, 1);
      // R4/R5: write every entry then sweep back
      for (int i = 0; i < 256; i++) begin
         do_wr(8'hF0, 8'(i));
         do_wr(8'hF1, 8'(i) ^ 8'h5A);
         if (!is_ro(i)) model[i] = 8'(i) ^ 8'h5A;
      end
      for (int i = 0; i < 256; i++) rd_entry(i, model[i], is_ro(i) ? "R5" : "R4");
      // R2: index port readback
      do_wr(8'hF0, 8'h77);
      do_rd(8'hF0, v, d);
      check("R2 readback", {v, d}, {1'b1, 8'h77});
      // R6: disabled decoder ignores everything
      do_wr(8'hF0, 8'hE0);
      en = 1'b0;
      do_wr(8'hF0, 8'hE1);
      do_wr(8'hF1, 8'h99);
      do_rd(8'hF1, v, d);
      check("R6 no data read", {v, d}, 9'h000);
      do_rd(8'hF0, v, d);
      check("R6 no index read", {v, d}, 9'h000);
      en = 1'b1;
      do_rd(8'hF0, v, d);
      check("R6 index kept", {v, d}, {1'b1, 8'hE0});
      do_rd(8'hF1, v, d);
      check("R6 entry kept", {v, d}, {1'b1, model['hE0]});
      // R10: other offsets ignored
      do_wr(8'h10, 8'hE2);
      do_rd(8'h10, v, d);
      check("R10 no read", {v, d}, 9'h000);
      do_rd(8'hF0, v, d);
      check("R10 index kept", {v, d}, {1'b1, 8'hE0});
      // R9: read and write in one cycle returns old contents
      @(negedge clk); addr = 8'hF1; wdata = 8'h66; wr = 1'b1; rd = 1'b1;
      @(negedge clk); wr = 1'b0; rd = 1'b0;
      check("R9 old value", {rvalid, rdata}, {1'b1, model['hE0]});
      model['hE0] = 8'h66;
      do_rd(8'hF1, v, d);
      check("R9 new value", {v, d}, {1'b1, 8'h66});
      // R1: second reset restores contents and clears flags
      apply_reset();
      check("R1 flag1 cleared", bad1, 0);
      check("R1 flag2 cleared", bad2, 0);
      rd_entry('hE0, 8'h3C, "R1 E0");
      rd_entry('hE6, 8'hDE, "R1 E6");
      rd_entry('hF0, 8'h00, "R1 F0");
      rd_entry('hE8, 8'hBE, "R1 E8");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule